// File: doc/BRIEF.md
# Indirect Register Access Bridge

This block lets a host processor reach a large downstream register space through a small window of four 32-bit host registers. The host stores a target address, and for stores a data word, in the window. It then writes a command word that asks for a single downstream read or write. The bridge performs that one transfer on a request/ready register bus and raises an acknowledge flag in the command word. The host polls for that flag, collects read data from the window, and finally writes zero to the command word so the bridge returns to idle.

Each transfer is therefore a handshake that the host drives and must close on purpose. Host accesses are not passed straight through to the bus. While a command is open, new request bits are refused. The downstream address, data and direction are captured when the command is accepted, so later host writes to the window cannot disturb a transfer that is already on the bus. Host reads are combinational: `hst_rdata` reflects the word selected by `hst_addr` in the same cycle.

Top module: `ibr_bridge`

## Requirements
- R1: After reset, every window register reads zero and `dn_req` is low.
- R2: Window layout by byte offset: 0x0 command, 0x4 target address (zero-extended on read), 0x8 read data (read-only; host writes to it have no effect), 0xC write data. The address and write-data words read back as written.
- R3: In idle, a command write with bit 0 set and bit 1 clear starts exactly one downstream read (`dn_we` low) at the stored address. On completion the command word reads 0x5 and offset 0x8 holds the fetched word.
- R4: In idle, a command write with bit 1 set and bit 0 clear starts exactly one downstream write (`dn_we` high) that carries the stored address and write data. On completion the command word reads 0x6.
- R5: `dn_req`, `dn_we`, `dn_addr` and `dn_wdata` hold steady until `dn_ready` is sampled high. Host writes to offsets 0x4 or 0xC during a transfer do not change it.
- R6: The acknowledge bit (bit 2) rises in the cycle after the handshake, and `dn_req` drops in that same cycle. The bit then stays set until the host clears the command.
- R7: A command write with bits 0 and 1 both clear clears every command bit, acknowledge included. The command word then reads exactly zero.
- R8: While a command is pending or acknowledged but not cleared, command writes that set a request bit are ignored, and no further downstream transfer starts.
- R9: A command write with both bits 0 and 1 set is invalid. It starts no transfer and leaves the command word at zero.
- R10: The read-data word changes only when a downstream read completes while its command is still standing. Otherwise it keeps its last value.
- R11: A clear issued while a transfer waits for `dn_ready` makes the command word read zero at once. The request still completes on the bus, but no acknowledge is raised and no data is captured. Request writes are ignored until that transfer finishes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hst_wr | input | 1 | Host write strobe, one cycle per write |
| hst_addr | input | HOST_AW | Host byte offset into the window |
| hst_wdata | input | DATA_W | Host write data |
| hst_rdata | output | DATA_W | Window word selected by hst_addr (combinational) |
| dn_req | output | 1 | Downstream request valid |
| dn_we | output | 1 | Downstream direction: 1 write, 0 read |
| dn_addr | output | DN_AW | Downstream register address |
| dn_wdata | output | DATA_W | Downstream write data |
| dn_rdata | input | DATA_W | Downstream read data, valid with dn_ready |
| dn_ready | input | 1 | Downstream completion, sampled with dn_req |

## Verification
The bench checks the exact cycle at which the acknowledge bit appears. A design that acknowledged on the handshake edge, or one cycle late, would miss that sample. It changes the window address and data while a slow transfer is still waiting. A bridge that drove the bus straight from the window registers would then send the wrong address to the scoreboard. It also issues a request while an acknowledged command is still standing, writes the invalid both-bits command, and clears a transfer before it completes. A careless design would answer these with a second bus transfer, a spurious acknowledge, or an overwritten read-data word, and the bench compares each of those against its transfer count and the read-data value it expects.

// File: rtl/ibr_pkg.sv
// Package: shared encodings for the indirect register bridge.
// Assumes a 16-byte host window with word-aligned registers.
package ibr_pkg;
    localparam int CMD_RD_BIT  = 0;
    localparam int CMD_WR_BIT  = 1;
    localparam int CMD_ACK_BIT = 2;

    typedef enum logic [1:0] {
        SEL_CMD   = 2'd0,
        SEL_ADDR  = 2'd1,
        SEL_RDATA = 2'd2,
        SEL_WDATA = 2'd3
    } reg_sel_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RUN   = 2'd1,
        ST_DONE  = 2'd2,
        ST_DRAIN = 2'd3
    } cmd_state_e;

    typedef struct packed {
        logic ack;
        logic wr;
        logic rd;
    } cmd_bits_t;
endpackage

// File: rtl/ibr_host_regs.sv
// Module: host-facing window. It decodes host writes into the address and
// write-data registers, flags command writes, and multiplexes read data.
// Assumes HOST_AW >= 4 and DN_AW <= DATA_W; address bits [1:0] are ignored.
module ibr_host_regs
    import ibr_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int DN_AW   = 16,
    parameter int HOST_AW = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               hst_wr,
    input  logic [HOST_AW-1:0] hst_addr,
    input  logic [DATA_W-1:0]  hst_wdata,
    output logic [DATA_W-1:0]  hst_rdata,
    input  cmd_bits_t          cmd_bits,
    input  logic [DATA_W-1:0]  rdata_q,
    output logic [DN_AW-1:0]   addr_q,
    output logic [DATA_W-1:0]  wdata_q,
    output logic               cmd_wr_stb,
    output logic [1:0]         cmd_req
);
    localparam int CMD_PAD = DATA_W - 3;

    reg_sel_e sel;
    logic     unused_host_bits;

    assign sel              = reg_sel_e'(hst_addr[3:2]);
    assign unused_host_bits = ^{hst_addr[1:0], hst_addr[HOST_AW-1:2]};

    // Flag command writes and pass the two request bits on.
    always_comb begin
        cmd_wr_stb = hst_wr && (sel == SEL_CMD);
        cmd_req    = hst_wdata[CMD_WR_BIT:CMD_RD_BIT];
    end

    // Capture the target address and write data from host writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
        end else if (hst_wr) begin
            if (sel == SEL_ADDR)  addr_q  <= hst_wdata[DN_AW-1:0];
            if (sel == SEL_WDATA) wdata_q <= hst_wdata;
        end
    end

    // Select the window word that the host is reading.
    always_comb begin
        unique case (sel)
            SEL_CMD:   hst_rdata = {{CMD_PAD{1'b0}}, cmd_bits};
            SEL_ADDR:  hst_rdata = DATA_W'(addr_q);
            SEL_RDATA: hst_rdata = rdata_q;
            default:   hst_rdata = wdata_q;
        endcase
    end
endmodule

// File: rtl/ibr_cmd_fsm.sv
// Module: command state machine. It accepts one request at a time,
// drives the downstream request with values captured at launch, raises the
// acknowledge bit after the handshake and captures read data.
// Assumes dn_rdata is valid in the cycle dn_ready is high.
module ibr_cmd_fsm
    import ibr_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int DN_AW  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_wr_stb,
    input  logic [1:0]        cmd_req,
    input  logic [DN_AW-1:0]  addr_q,
    input  logic [DATA_W-1:0] wdata_q,
    output cmd_bits_t         cmd_bits,
    output logic [DATA_W-1:0] rdata_q,
    output logic              dn_req,
    output logic              dn_we,
    output logic [DN_AW-1:0]  dn_addr,
    output logic [DATA_W-1:0] dn_wdata,
    input  logic [DATA_W-1:0] dn_rdata,
    input  logic              dn_ready
);
    cmd_state_e state, state_nx;
    logic clear_cmd, start_rd, start_wr, start, hs, finish;

    // Classify this cycle's command write and the bus handshake.
    always_comb begin
        clear_cmd = cmd_wr_stb && (cmd_req == 2'b00);
        start_rd  = cmd_wr_stb && (cmd_req == 2'b01) && (state == ST_IDLE);
        start_wr  = cmd_wr_stb && (cmd_req == 2'b10) && (state == ST_IDLE);
        start     = start_rd || start_wr;
        hs        = dn_req && dn_ready;
        finish    = (state == ST_RUN) && hs && !clear_cmd;
    end

    // Next-state decision for the command sequence.
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (start) state_nx = ST_RUN;
            ST_RUN: begin
                if (clear_cmd)  state_nx = hs ? ST_IDLE : ST_DRAIN;
                else if (hs)    state_nx = ST_DONE;
            end
            ST_DONE:  if (clear_cmd) state_nx = ST_IDLE;
            default:  if (hs) state_nx = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Host-visible command bits: set on launch, ack on finish, clear on zero.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_cmd) begin
            cmd_bits <= '0;
        end else if (start) begin
            cmd_bits.rd <= start_rd;
            cmd_bits.wr <= start_wr;
        end else if (finish) begin
            cmd_bits.ack <= 1'b1;
        end
    end

    // Downstream request and its captured address, data and direction.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dn_req   <= 1'b0;
            dn_we    <= 1'b0;
            dn_addr  <= '0;
            dn_wdata <= '0;
        end else if (start) begin
            dn_req   <= 1'b1;
            dn_we    <= start_wr;
            dn_addr  <= addr_q;
            dn_wdata <= wdata_q;
        end else if (hs) begin
            dn_req   <= 1'b0;
        end
    end

    // Read-data capture on a read that completes with its command standing.
    always_ff @(posedge clk) begin
        if (!rst_n)                rdata_q <= '0;
        else if (finish && !dn_we) rdata_q <= dn_rdata;
    end
endmodule

// File: rtl/ibr_bridge.sv
// Module: top of the indirect register bridge. It joins the host window
// decoder and the command state machine. Host reads are combinational;
// one downstream transfer is outstanding at most.
module ibr_bridge
    import ibr_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int DN_AW   = 16,
    parameter int HOST_AW = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               hst_wr,
    input  logic [HOST_AW-1:0] hst_addr,
    input  logic [DATA_W-1:0]  hst_wdata,
    output logic [DATA_W-1:0]  hst_rdata,
    output logic               dn_req,
    output logic               dn_we,
    output logic [DN_AW-1:0]   dn_addr,
    output logic [DATA_W-1:0]  dn_wdata,
    input  logic [DATA_W-1:0]  dn_rdata,
    input  logic               dn_ready
);
    cmd_bits_t         cmd_bits;
    logic [DATA_W-1:0] rdata_q;
    logic [DN_AW-1:0]  addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic              cmd_wr_stb;
    logic [1:0]        cmd_req;

    ibr_host_regs #(.DATA_W(DATA_W), .DN_AW(DN_AW), .HOST_AW(HOST_AW)) u_regs (
        .clk(clk), .rst_n(rst_n), .hst_wr(hst_wr), .hst_addr(hst_addr),
        .hst_wdata(hst_wdata), .hst_rdata(hst_rdata), .cmd_bits(cmd_bits),
        .rdata_q(rdata_q), .addr_q(addr_q), .wdata_q(wdata_q),
        .cmd_wr_stb(cmd_wr_stb), .cmd_req(cmd_req)
    );

    ibr_cmd_fsm #(.DATA_W(DATA_W), .DN_AW(DN_AW)) u_fsm (
        .clk(clk), .rst_n(rst_n), .cmd_wr_stb(cmd_wr_stb), .cmd_req(cmd_req),
        .addr_q(addr_q), .wdata_q(wdata_q), .cmd_bits(cmd_bits),
        .rdata_q(rdata_q), .dn_req(dn_req), .dn_we(dn_we), .dn_addr(dn_addr),
        .dn_wdata(dn_wdata), .dn_rdata(dn_rdata), .dn_ready(dn_ready)
    );
endmodule

// File: rtl/ibr_checks.sv
// Module: protocol checker for ibr_bridge, attached by bind. It watches
// host command writes, the command word and the downstream bus.
module ibr_checks #(
    parameter int DATA_W = 32,
    parameter int DN_AW  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              hst_wr,
    input logic [1:0]        win_sel,
    input logic [1:0]        cmd_lo,
    input logic [2:0]        cmd_word,
    input logic              dn_req,
    input logic              dn_we,
    input logic [DN_AW-1:0]  dn_addr,
    input logic [DATA_W-1:0] dn_wdata,
    input logic              dn_ready
);
    logic clear_wr, req_wr, both_wr;

    assign clear_wr = hst_wr && (win_sel == 2'd0) && (cmd_lo == 2'b00);
    assign req_wr   = hst_wr && (win_sel == 2'd0) && (cmd_lo != 2'b00);
    assign both_wr  = hst_wr && (win_sel == 2'd0) && (cmd_lo == 2'b11);

    assert_req_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        dn_req && !dn_ready |=> dn_req && $stable(dn_addr) && $stable(dn_we) && $stable(dn_wdata));

    assert_ack_after_hs_R6: assert property (@(posedge clk) disable iff (!rst_n)
        dn_req && dn_ready && (cmd_word[1:0] != 2'b00) && !clear_wr |=> cmd_word[2] && !dn_req);

    assert_ack_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_word[2] && !clear_wr |=> cmd_word[2]);

    assert_clear_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        clear_wr |=> cmd_word == 3'b000);

    assert_busy_ignore_R8: assert property (@(posedge clk) disable iff (!rst_n)
        req_wr && (cmd_word[1:0] != 2'b00 || dn_req) |=> $stable(cmd_word[1:0]));

    assert_single_dir_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cmd_word[1:0]));

    assert_invalid_cmd_R9: assert property (@(posedge clk) disable iff (!rst_n)
        both_wr && !dn_req && cmd_word == 3'b000 |=> !dn_req && cmd_word == 3'b000);

    assert_drain_no_ack_R11: assert property (@(posedge clk) disable iff (!rst_n)
        dn_req && cmd_word == 3'b000 |=> cmd_word == 3'b000);
endmodule

bind ibr_bridge ibr_checks #(.DATA_W(DATA_W), .DN_AW(DN_AW)) u_checks (
    .clk(clk), .rst_n(rst_n), .hst_wr(hst_wr), .win_sel(hst_addr[3:2]),
    .cmd_lo(hst_wdata[1:0]), .cmd_word(cmd_bits), .dn_req(dn_req),
    .dn_we(dn_we), .dn_addr(dn_addr), .dn_wdata(dn_wdata), .dn_ready(dn_ready)
);

// File: tb/test_ibr_bridge.sv
// Bench for ibr_bridge: scoreboard of expected downstream transfers plus
// host-side checks of the window registers.
module test_ibr_bridge;
    localparam int DATA_W  = 32;
    localparam int DN_AW   = 16;
    localparam int HOST_AW = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              hst_wr = 1'b0;
    logic [HOST_AW-1:0] hst_addr = '0;
    logic [DATA_W-1:0] hst_wdata = '0;
    logic [DATA_W-1:0] hst_rdata;
    logic              dn_req, dn_we;
    logic [DN_AW-1:0]  dn_addr;
    logic [DATA_W-1:0] dn_wdata, dn_rdata;
    logic              dn_ready = 1'b0;

    always #4 clk = ~clk;

    ibr_bridge #(.DATA_W(DATA_W), .DN_AW(DN_AW), .HOST_AW(HOST_AW)) i_ibr_bridge (
        .clk(clk), .rst_n(rst_n), .hst_wr(hst_wr), .hst_addr(hst_addr),
        .hst_wdata(hst_wdata), .hst_rdata(hst_rdata), .dn_req(dn_req),
        .dn_we(dn_we), .dn_addr(dn_addr), .dn_wdata(dn_wdata),
        .dn_rdata(dn_rdata), .dn_ready(dn_ready)
    );

    int n_tests = 0;
    int n_fail  = 0;
    int hs_count = 0;
    int fixed_delay = -1;
    int wait_left = 0;
    bit done = 1'b0;

    logic [DATA_W-1:0] mem [16];
    assign dn_rdata = mem[dn_addr[3:0]];

    typedef struct {
        logic              we;
        logic [DN_AW-1:0]  a;
        logic [DATA_W-1:0] d;
    } dn_item_t;
    dn_item_t exp_q[$];

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Downstream ready model: waits a fixed or random number of cycles.
    always @(negedge clk) begin
        if (!dn_req) begin
            dn_ready = 1'b0;
            wait_left = (fixed_delay >= 0) ? fixed_delay : int'($urandom_range(0, 3));
        end else if (!dn_ready) begin
            if (wait_left == 0) dn_ready = 1'b1;
            else wait_left--;
        end
    end

    // Monitor: compare every handshake with the scoreboard queue.
    always @(posedge clk) begin
        if (rst_n && dn_req && dn_ready) begin
            hs_count++;
            if (dn_we) mem[dn_addr[3:0]] <= dn_wdata;
            if (exp_q.size() == 0) begin
                check(1'b0, "R8 unexpected transfer", {16'h0, dn_addr}, 32'h0);
            end else begin
                dn_item_t e;
                e = exp_q.pop_front();
                check(dn_we == e.we, "R3/R4 direction", {31'h0, dn_we}, {31'h0, e.we});
                check(dn_addr == e.a, "R5 address", {16'h0, dn_addr}, {16'h0, e.a});
                if (e.we) check(dn_wdata == e.d, "R5 write data", dn_wdata, e.d);
            end
        end
    end

    task automatic host_write(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        hst_wr = 1'b1; hst_addr = a; hst_wdata = d;
        @(negedge clk);
        hst_wr = 1'b0;
    endtask

    task automatic host_read(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        hst_addr = a;
        #1 d = hst_rdata;
    endtask

    task automatic wait_ack(output logic [31:0] c);
        c = '0;
        for (int i = 0; i < 60 && !c[2]; i++) host_read(4'h0, c);
    endtask

    task automatic launch_read(input logic [DN_AW-1:0] a);
        dn_item_t e;
        e.we = 1'b0; e.a = a; e.d = '0;
        exp_q.push_back(e);
        host_write(4'h4, {16'h0, a});
        host_write(4'h0, 32'h1);
    endtask

    task automatic launch_write(input logic [DN_AW-1:0] a, input logic [31:0] d);
        dn_item_t e;
        e.we = 1'b1; e.a = a; e.d = d;
        exp_q.push_back(e);
        host_write(4'hC, d);
        host_write(4'h4, {16'h0, a});
        host_write(4'h0, 32'h2);
    endtask

    task automatic report();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            report();
        end
    end

    initial begin
        logic [31:0] v;
        logic [31:0] held;
        int hs0;
        for (int i = 0; i < 16; i++) mem[i] = 32'hC0DE0000 + 32'(i * 32'h111);
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1: reset state
        for (int i = 0; i < 4; i++) begin
            host_read(4'(i * 4), v);
            check(v == 32'h0, "R1 window reset", v, 32'h0);
        end
        check(dn_req == 1'b0, "R1 request idle", {31'h0, dn_req}, 32'h0);

        // R6: exact acknowledge timing with zero ready delay (R3 read)
        fixed_delay = 0;
        launch_read(16'd3);
        #1 check(hst_rdata == 32'h1, "R6 no ack before handshake", hst_rdata, 32'h1);
        @(negedge clk); #1;
        check(hst_rdata == 32'h5, "R6 ack one cycle after handshake", hst_rdata, 32'h5);
        check(dn_req == 1'b0, "R6 request dropped", {31'h0, dn_req}, 32'h0);
        host_read(4'h8, v);
        check(v == mem[3], "R3 fetched data", v, mem[3]);

        // R7: clear returns exactly zero
        host_write(4'h0, 32'h0);
        host_read(4'h0, v);
        check(v == 32'h0, "R7 cleared command", v, 32'h0);

        // R4: write then read back with random ready delay
        fixed_delay = -1;
        launch_write(16'd5, 32'h1234_ABCD);
        wait_ack(v);
        check(v == 32'h6, "R4 write acknowledged", v, 32'h6);
        host_read(4'h8, v);
        check(v == mem[3], "R10 read data kept over write", v, mem[3]);
        host_write(4'h0, 32'h0);
        launch_read(16'd5);
        wait_ack(v);
        check(v == 32'h5, "R3 read acknowledged", v, 32'h5);
        host_read(4'h8, v);
        check(v == 32'h1234_ABCD, "R4 write effect", v, 32'h1234_ABCD);

        // R8/R6: request while acknowledged is ignored; ack stays set
        hs0 = hs_count;
        host_write(4'h0, 32'h2);
        repeat (10) @(negedge clk);
        host_read(4'h0, v);
        check(v == 32'h5, "R8/R6 command held after ignored request", v, 32'h5);
        check(hs_count == hs0, "R8 no extra transfer", hs_count, hs0);
        host_write(4'h0, 32'h0);

        // R2: read-data register is read-only; address and data read back
        host_write(4'h8, 32'hFFFF_FFFF);
        host_read(4'h8, v);
        check(v == 32'h1234_ABCD, "R2 read-data write ignored", v, 32'h1234_ABCD);
        host_read(4'h4, v);
        check(v == 32'h5, "R2 address readback", v, 32'h5);
        host_read(4'hC, v);
        check(v == 32'h1234_ABCD, "R2 write-data readback", v, 32'h1234_ABCD);

        // R9: both request bits set is invalid
        hs0 = hs_count;
        host_write(4'h0, 32'h3);
        repeat (6) @(negedge clk);
        host_read(4'h0, v);
        check(v == 32'h0, "R9 invalid command word", v, 32'h0);
        check(hs_count == hs0, "R9 no transfer", hs_count, hs0);

        // R5: window changes during a slow transfer do not reach the bus
        fixed_delay = 5;
        launch_write(16'd9, 32'hFEED_0009);
        host_write(4'h4, 32'h2);
        host_write(4'hC, 32'hDEAD_DEAD);
        wait_ack(v);
        check(v == 32'h6, "R5 slow write acknowledged", v, 32'h6);
        check(mem[9] == 32'hFEED_0009, "R5 latched data written", mem[9], 32'hFEED_0009);
        host_write(4'h0, 32'h0);

        // R11: clear while waiting for ready
        fixed_delay = 6;
        host_read(4'h8, held);
        hs0 = hs_count;
        launch_read(16'd7);
        host_write(4'h0, 32'h0);
        host_read(4'h0, v);
        check(v == 32'h0, "R11 command zero after early clear", v, 32'h0);
        check(dn_req == 1'b1, "R11 request still pending", {31'h0, dn_req}, 32'h1);
        host_write(4'h0, 32'h1);
        repeat (14) @(negedge clk);
        host_read(4'h0, v);
        check(v == 32'h0, "R11 no ack after drain", v, 32'h0);
        check(hs_count == hs0 + 1, "R11 single transfer completed", hs_count, hs0 + 1);
        host_read(4'h8, v);
        check(v == held, "R10 read data not captured on cleared read", v, held);

        check(exp_q.size() == 0, "R3/R4 all expected transfers seen", exp_q.size(), 0);
        done = 1'b1;
        report();
    end
endmodule